// File: doc/BRIEF.md
# Radio Packet Sequencer

This block is the host-side controller for a 2.4 GHz packet radio. It owns the radio's chip-enable line and issues every register access as a request to a separate SPI command engine. A request carries the opcode, which is the first byte on the wire, and the number of data bytes that follow. Data bytes that the sequencer supplies travel on a valid/ready byte stream. Bytes the radio returns come back on a valid-only byte stream. The engine ends each request with a one-cycle done strobe and the status byte it clocked in during the opcode.

After reset the sequencer configures the radio without being asked. It then waits in idle for one of two flows. The send flow loads one fixed-width payload from the host byte stream, switches the radio to the transmit role and fires a timed chip-enable pulse. The receive flow switches the radio to the receive role and raises chip-enable. It waits a settle time, counted in system clocks, and then polls the status byte. If a packet is waiting, the sequencer reads it out to the host and reports it as valid. Each flow ends with a write-back of the polled status, which clears the interrupt flags.

The states are ST_INIT/ST_INIT_W (issue and finish one init write), ST_IDLE, ST_TX_LOAD/ST_TX_LOAD_W, ST_TX_CFG/ST_TX_CFG_W, ST_TX_PULSE, ST_RX_CFG/ST_RX_CFG_W, ST_RX_SETTLE, ST_RX_POLL/ST_RX_POLL_W, ST_RX_READ/ST_RX_READ_W, ST_RX_CLR/ST_RX_CLR_W and ST_FINISH. Each issue state moves to its wait state when cmd_ready is high. Each wait state moves on when cmd_done is high. ST_INIT_W returns to ST_INIT until the tenth write is done, and then goes to ST_IDLE. ST_IDLE goes to ST_TX_LOAD on start_tx, or otherwise to ST_RX_CFG on start_rx. ST_TX_PULSE and ST_RX_SETTLE leave when their timer expires. ST_RX_POLL_W goes to ST_RX_READ if status bit 6 is set, or otherwise to ST_RX_CLR. ST_FINISH always returns to ST_IDLE.

Top module: `rf_pkt_seq`

## Requirements
- R1: After reset, ce is low and busy is high, and ten one-byte or multi-byte register writes are issued in this order. Each write opcode is 0x20 OR the register number. The writes, as register/value, are 0x00/0x0F, 0x01/0x01, 0x02/0x01, 0x03/0x02, 0x04/0x1A, 0x05/0x00, 0x06/0x07 and 0x11/PLD_W, followed by the address writes to 0x10 and 0x0A.
- R2: When the init writes are complete, ce goes high and busy goes low. While idle with no start request, ce does not change.
- R3: start_tx and start_rx are acted on only while busy is low, and a start request raised while busy has no effect. When both are raised in the same idle cycle, the send flow runs and the receive request is dropped.
- R4: The send flow drives ce low when it accepts the request. It then issues the payload load (opcode 0xA0, PLD_W bytes taken in order from the host byte stream), followed by a write of 0x0E to register 0x00.
- R5: After that write, ce is high for exactly ceil(CLK_HZ × PULSE_US / 10^6) cycles and then returns low.
- R6: The receive flow drives ce low when it accepts the request, writes 0x0F to register 0x00 and then raises ce. The status poll (opcode 0xFF, zero data bytes) is requested exactly ceil(CLK_HZ × SETTLE_US / 10^6) cycles after ce rises.
- R7: If bit 6 of the polled status is set, ce drops. The sequencer then requests a payload read (opcode 0x61, PLD_W bytes) and forwards every returned byte on rx_data/rx_valid.
- R8: Every receive flow ends by writing the polled status value back to register 0x07 (opcode 0x27).
- R9: done is a one-cycle pulse at the end of each flow and falls in the first cycle in which busy is low. rx_ok is high together with done exactly when the receive flow found bit 6 set.
- R10: A receive flow that finds no packet leaves ce high.
- R11: Once cmd_valid is raised, it stays high and cmd_op and cmd_len do not change until cmd_ready is seen. cmd_valid is high only while busy is high.
- R12: Each address write carries ADDR_BYTES bytes of ADDR, least significant byte first, and both address writes carry the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_tx | input | 1 | Request the send flow |
| start_rx | input | 1 | Request the receive flow |
| busy | output | 1 | High from acceptance until the flow ends (and during init) |
| done | output | 1 | One-cycle end-of-flow pulse |
| rx_ok | output | 1 | With done: a payload was received |
| host_tx_data | input | 8 | Payload byte from the host |
| host_tx_valid | input | 1 | Host payload byte valid |
| host_tx_ready | output | 1 | Host payload byte taken |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | Received payload byte valid |
| ce | output | 1 | Radio chip-enable |
| cmd_valid | output | 1 | Command request to the SPI engine |
| cmd_ready | input | 1 | Engine accepts the request |
| cmd_op | output | 8 | Command opcode byte |
| cmd_len | output | LEN_W | Number of data bytes after the opcode |
| wbyte_data | output | 8 | Data byte to the engine |
| wbyte_valid | output | 1 | Data byte valid |
| wbyte_ready | input | 1 | Engine takes the data byte |
| rbyte_data | input | 8 | Byte returned by the engine |
| rbyte_valid | input | 1 | Returned byte valid |
| cmd_done | input | 1 | Engine finished the request |
| cmd_status | input | 8 | Status byte captured during the opcode |

## Verification
Both start requests can arrive in the same idle cycle. The bench provokes this by raising start_tx and start_rx on one clock edge. It judges the result from the engine-side command log, which must show a payload load followed by a single config write and no status poll. The bench also checks that done ends the run with rx_ok low. A second collision, a start request arriving while a flow is busy, is judged by the same log: once the running flow completes, the log must contain no extra commands.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;

    typedef enum logic [4:0] {
        ST_INIT, ST_INIT_W, ST_IDLE,
        ST_TX_LOAD, ST_TX_LOAD_W, ST_TX_CFG, ST_TX_CFG_W, ST_TX_PULSE,
        ST_RX_CFG, ST_RX_CFG_W, ST_RX_SETTLE, ST_RX_POLL, ST_RX_POLL_W,
        ST_RX_READ, ST_RX_READ_W, ST_RX_CLR, ST_RX_CLR_W, ST_FINISH
    } seq_state_e;

    // opcodes seen by the command engine
    localparam logic [7:0] OP_WREG = 8'h20;
    localparam logic [7:0] OP_LOAD = 8'hA0;
    localparam logic [7:0] OP_READ = 8'h61;
    localparam logic [7:0] OP_NOP  = 8'hFF;

    // register numbers the flows touch directly
    localparam logic [4:0] REG_MODE   = 5'h00;
    localparam logic [4:0] REG_FLAGS  = 5'h07;

    localparam logic [7:0] MODE_TX = 8'h0E;
    localparam logic [7:0] MODE_RX = 8'h0F;
    localparam int         RX_HIT_BIT = 6;
    localparam int         INIT_STEPS = 10;

endpackage

// File: rtl/rfseq_timer.sv
module rfseq_timer #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rfseq_init_table.sv
module rfseq_init_table
    import rfseq_pkg::*;
#(
    parameter int unsigned PLD_W      = 32,
    parameter int unsigned ADDR_BYTES = 5,
    parameter logic [8*ADDR_BYTES-1:0] ADDR = '0,
    parameter logic [7:0]  AW_CODE    = 8'h02,
    parameter int unsigned LEN_W      = 6
) (
    input  logic [3:0]       step,
    input  logic [LEN_W-1:0] bidx,
    output logic [7:0]       op,
    output logic [LEN_W-1:0] len,
    output logic [7:0]       data
);
    logic [7:0] addr_b [ADDR_BYTES];
    logic [7:0] addr_sel;
    logic [4:0] reg_no;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign addr_b[g] = ADDR[8*g +: 8];
    end

    always_comb begin
        addr_sel = 8'h00;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (bidx == LEN_W'(i)) addr_sel = addr_b[i];
    end

    always_comb begin
        len = LEN_W'(1);
        unique case (step)
            4'd0:    begin reg_no = REG_MODE; data = MODE_RX;     end
            4'd1:    begin reg_no = 5'h01;    data = 8'h01;       end // pipe-0 auto-ack
            4'd2:    begin reg_no = 5'h02;    data = 8'h01;       end // pipe-0 enable
            4'd3:    begin reg_no = 5'h03;    data = AW_CODE;     end // address width
            4'd4:    begin reg_no = 5'h04;    data = 8'h1A;       end // retry setup
            4'd5:    begin reg_no = 5'h05;    data = 8'h00;       end // channel
            4'd6:    begin reg_no = 5'h06;    data = 8'h07;       end // rate / power
            4'd7:    begin reg_no = 5'h11;    data = 8'(PLD_W);   end // pipe-0 width
            4'd8:    begin reg_no = 5'h10;    data = addr_sel; len = LEN_W'(ADDR_BYTES); end
            4'd9:    begin reg_no = 5'h0A;    data = addr_sel; len = LEN_W'(ADDR_BYTES); end
            default: begin reg_no = REG_MODE; data = MODE_RX;     end
        endcase
        op = OP_WREG | {3'b000, reg_no};
    end
endmodule

// File: rtl/rf_pkt_seq.sv
module rf_pkt_seq
    import rfseq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 250_000_000,
    parameter int unsigned PLD_W      = 32,
    parameter int unsigned ADDR_BYTES = 5,
    parameter logic [8*ADDR_BYTES-1:0] ADDR = 40'hE7E7E7E7E7,
    parameter logic [7:0]  AW_CODE    = 8'h02,
    parameter int unsigned PULSE_US   = 10,
    parameter int unsigned SETTLE_US  = 130,
    parameter int unsigned LEN_W      = $clog2(PLD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_tx,
    input  logic             start_rx,
    output logic             busy,
    output logic             done,
    output logic             rx_ok,
    input  logic [7:0]       host_tx_data,
    input  logic             host_tx_valid,
    output logic             host_tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             ce,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [7:0]       cmd_op,
    output logic [LEN_W-1:0] cmd_len,
    output logic [7:0]       wbyte_data,
    output logic             wbyte_valid,
    input  logic             wbyte_ready,
    input  logic [7:0]       rbyte_data,
    input  logic             rbyte_valid,
    input  logic             cmd_done,
    input  logic [7:0]       cmd_status
);
    // minimum times rounded up to whole clocks
    localparam longint unsigned PULSE_L  = (64'(CLK_HZ) * 64'(PULSE_US)  + 64'd999_999) / 64'd1_000_000;
    localparam longint unsigned SETTLE_L = (64'(CLK_HZ) * 64'(SETTLE_US) + 64'd999_999) / 64'd1_000_000;
    localparam int unsigned PULSE_CYC  = (PULSE_L  < 1) ? 1 : 32'(PULSE_L);
    localparam int unsigned SETTLE_CYC = (SETTLE_L < 1) ? 1 : 32'(SETTLE_L);
    localparam int unsigned MAX_CYC    = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_d;
    logic [3:0]       step_q;
    logic [LEN_W-1:0] bidx_q;
    logic [7:0]       stat_q;
    logic             hit_q, ce_q, done_q, rxok_q;
    logic             accept, tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic [7:0]       ini_op, ini_data;
    logic [LEN_W-1:0] ini_len;

    rfseq_init_table #(
        .PLD_W(PLD_W), .ADDR_BYTES(ADDR_BYTES), .ADDR(ADDR),
        .AW_CODE(AW_CODE), .LEN_W(LEN_W)
    ) u_table (
        .step(step_q), .bidx(bidx_q), .op(ini_op), .len(ini_len), .data(ini_data)
    );

    rfseq_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    assign accept   = (state_q == ST_IDLE) && (start_tx || start_rx);
    assign tmr_load = cmd_done && (state_q == ST_TX_CFG_W || state_q == ST_RX_CFG_W);
    assign tmr_val  = (state_q == ST_TX_CFG_W) ? TMR_W'(PULSE_CYC - 1) : TMR_W'(SETTLE_CYC - 1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:      if (cmd_ready) state_d = ST_INIT_W;
            ST_INIT_W:    if (cmd_done)  state_d = (step_q == 4'(INIT_STEPS - 1)) ? ST_IDLE : ST_INIT;
            ST_IDLE:      if (start_tx)  state_d = ST_TX_LOAD;
                          else if (start_rx) state_d = ST_RX_CFG;
            ST_TX_LOAD:   if (cmd_ready) state_d = ST_TX_LOAD_W;
            ST_TX_LOAD_W: if (cmd_done)  state_d = ST_TX_CFG;
            ST_TX_CFG:    if (cmd_ready) state_d = ST_TX_CFG_W;
            ST_TX_CFG_W:  if (cmd_done)  state_d = ST_TX_PULSE;
            ST_TX_PULSE:  if (tmr_zero)  state_d = ST_FINISH;
            ST_RX_CFG:    if (cmd_ready) state_d = ST_RX_CFG_W;
            ST_RX_CFG_W:  if (cmd_done)  state_d = ST_RX_SETTLE;
            ST_RX_SETTLE: if (tmr_zero)  state_d = ST_RX_POLL;
            ST_RX_POLL:   if (cmd_ready) state_d = ST_RX_POLL_W;
            ST_RX_POLL_W: if (cmd_done)  state_d = cmd_status[RX_HIT_BIT] ? ST_RX_READ : ST_RX_CLR;
            ST_RX_READ:   if (cmd_ready) state_d = ST_RX_READ_W;
            ST_RX_READ_W: if (cmd_done)  state_d = ST_RX_CLR;
            ST_RX_CLR:    if (cmd_ready) state_d = ST_RX_CLR_W;
            ST_RX_CLR_W:  if (cmd_done)  state_d = ST_FINISH;
            ST_FINISH:                   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0; bidx_q <= '0; stat_q <= '0; hit_q <= 1'b0;
            ce_q <= 1'b0; done_q <= 1'b0; rxok_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINISH);
            rxok_q <= (state_q == ST_FINISH) && hit_q;
            if (state_q == ST_INIT_W && cmd_done) step_q <= step_q + 1'b1;
            if (cmd_valid && cmd_ready)           bidx_q <= '0;
            else if (wbyte_valid && wbyte_ready)  bidx_q <= bidx_q + 1'b1;
            if (accept) begin
                ce_q  <= 1'b0;
                hit_q <= 1'b0;
            end
            if (state_q == ST_RX_POLL_W && cmd_done) begin
                stat_q <= cmd_status;
                hit_q  <= cmd_status[RX_HIT_BIT];
                if (cmd_status[RX_HIT_BIT]) ce_q <= 1'b0;
            end
            if (state_q == ST_INIT_W && cmd_done && step_q == 4'(INIT_STEPS - 1)) ce_q <= 1'b1;
            if (tmr_load)                              ce_q <= 1'b1;
            if (state_q == ST_TX_PULSE && tmr_zero)    ce_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cmd_valid     = 1'b0;
        cmd_op        = OP_NOP;
        cmd_len       = '0;
        wbyte_valid   = 1'b0;
        wbyte_data    = 8'h00;
        host_tx_ready = 1'b0;
        unique case (state_q)
            ST_INIT, ST_INIT_W: begin
                cmd_valid   = (state_q == ST_INIT);
                cmd_op      = ini_op;
                cmd_len     = ini_len;
                wbyte_valid = (state_q == ST_INIT_W);
                wbyte_data  = ini_data;
            end
            ST_TX_LOAD, ST_TX_LOAD_W: begin
                cmd_valid     = (state_q == ST_TX_LOAD);
                cmd_op        = OP_LOAD;
                cmd_len       = LEN_W'(PLD_W);
                wbyte_valid   = (state_q == ST_TX_LOAD_W) && host_tx_valid;
                wbyte_data    = host_tx_data;
                host_tx_ready = (state_q == ST_TX_LOAD_W) && wbyte_ready;
            end
            ST_TX_CFG, ST_TX_CFG_W, ST_RX_CFG, ST_RX_CFG_W: begin
                cmd_valid   = (state_q == ST_TX_CFG) || (state_q == ST_RX_CFG);
                cmd_op      = OP_WREG | {3'b000, REG_MODE};
                cmd_len     = LEN_W'(1);
                wbyte_valid = (state_q == ST_TX_CFG_W) || (state_q == ST_RX_CFG_W);
                wbyte_data  = (state_q == ST_TX_CFG || state_q == ST_TX_CFG_W) ? MODE_TX : MODE_RX;
            end
            ST_RX_POLL, ST_RX_POLL_W: begin
                cmd_valid = (state_q == ST_RX_POLL);
                cmd_op    = OP_NOP;
            end
            ST_RX_READ, ST_RX_READ_W: begin
                cmd_valid = (state_q == ST_RX_READ);
                cmd_op    = OP_READ;
                cmd_len   = LEN_W'(PLD_W);
            end
            ST_RX_CLR, ST_RX_CLR_W: begin
                cmd_valid   = (state_q == ST_RX_CLR);
                cmd_op      = OP_WREG | {3'b000, REG_FLAGS};
                cmd_len     = LEN_W'(1);
                wbyte_valid = (state_q == ST_RX_CLR_W);
                wbyte_data  = stat_q;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign rx_ok    = rxok_q;
    assign ce       = ce_q;
    assign rx_valid = (state_q == ST_RX_READ_W) && rbyte_valid;
    assign rx_data  = rbyte_data;
endmodule

// File: rtl/rfseq_chk.sv
module rfseq_chk #(
    parameter int unsigned LEN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_tx,
    input logic             start_rx,
    input logic             busy,
    input logic             done,
    input logic             rx_ok,
    input logic             ce,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [7:0]       cmd_op,
    input logic [LEN_W-1:0] cmd_len,
    input logic             rx_valid
);
    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_len));

    p_cmd_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_rxok_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |-> done);

    p_read_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !ce);

    p_idle_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start_tx && !start_rx |=> $stable(ce));
endmodule

bind rf_pkt_seq rfseq_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_rf_pkt_seq.sv
module tb_rf_pkt_seq;
    localparam int unsigned PLD_W   = 8;
    localparam int unsigned LEN_W   = 4;
    localparam logic [39:0] ADDR    = 40'hC2_B7_A5_93_1E;
    // 12.345 MHz: 10 us -> 123.45 -> 124 clocks, 130 us -> 1604.85 -> 1605 clocks
    localparam int EXP_PULSE  = 124;
    localparam int EXP_SETTLE = 1605;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_tx = 1'b0, start_rx = 1'b0;
    logic busy, done, rx_ok, host_tx_ready, rx_valid, ce, cmd_valid, wbyte_valid;
    logic [7:0] rx_data, cmd_op, wbyte_data, host_tx_data;
    logic [LEN_W-1:0] cmd_len;
    logic cmd_ready, wbyte_ready, rbyte_valid, cmd_done;
    logic [7:0] rbyte_data, cmd_status;
    logic host_tx_valid = 1'b1;

    logic [7:0] pay [PLD_W];
    logic [7:0] rxpay [PLD_W];
    int hidx = 0;
    assign host_tx_data = pay[hidx % PLD_W];

    int nchk = 0, nfail = 0, cyc = 0;
    int nlog = 0, nw = 0, nrx = 0;
    logic [7:0] op_log [64];
    int len_log [64], dat0_log [64], wstart [64], acc_cyc [64];
    logic ce_log [64];
    logic [7:0] wlog [512];
    logic [7:0] rxcap [64];
    logic [7:0] mstat = 8'h0E;
    int ce_rise = 0, ce_width = 0;
    logic ce_prev = 1'b0;

    rf_pkt_seq #(.CLK_HZ(12_345_000), .PLD_W(PLD_W), .ADDR_BYTES(5), .ADDR(ADDR)) dut (
        .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
        .busy(busy), .done(done), .rx_ok(rx_ok),
        .host_tx_data(host_tx_data), .host_tx_valid(host_tx_valid), .host_tx_ready(host_tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .ce(ce),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_len(cmd_len),
        .wbyte_data(wbyte_data), .wbyte_valid(wbyte_valid), .wbyte_ready(wbyte_ready),
        .rbyte_data(rbyte_data), .rbyte_valid(rbyte_valid),
        .cmd_done(cmd_done), .cmd_status(cmd_status)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // ce monitor
    initial forever begin
        @(negedge clk);
        if (ce && !ce_prev) ce_rise = cyc;
        if (!ce && ce_prev) ce_width = cyc - ce_rise;
        ce_prev = ce;
    end

    // behavioural SPI command engine
    initial begin
        logic [7:0] cur_op;
        int cur_len;
        cmd_ready = 0; wbyte_ready = 0; rbyte_valid = 0; rbyte_data = 0;
        cmd_done = 0; cmd_status = 0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid && nlog < 64) begin
                cur_op = cmd_op; cur_len = int'(cmd_len);
                op_log[nlog] = cur_op; len_log[nlog] = cur_len; ce_log[nlog] = ce;
                acc_cyc[nlog] = cyc; wstart[nlog] = nw; dat0_log[nlog] = 0;
                cmd_ready = 1;
                @(negedge clk);
                cmd_ready = 0;
                if (cur_op == 8'hA0 || cur_op[7:5] == 3'b001) begin
                    for (int k = 0; k < cur_len; k++) begin
                        wbyte_ready = 1;
                        while (!wbyte_valid) @(negedge clk);
                        if (k == 0) dat0_log[nlog] = int'(wbyte_data);
                        if (nw < 512) wlog[nw] = wbyte_data;
                        nw++;
                        @(posedge clk); #1;
                        wbyte_ready = 0;
                        if (cur_op == 8'hA0) hidx++;
                        @(negedge clk);
                    end
                end else if (cur_op == 8'h61) begin
                    for (int k = 0; k < cur_len; k++) begin
                        rbyte_valid = 1; rbyte_data = rxpay[k % PLD_W];
                        #1;
                        if (rx_valid && nrx < 64) begin rxcap[nrx] = rx_data; nrx++; end
                        @(negedge clk);
                    end
                    rbyte_valid = 0;
                end
                cmd_status = mstat;
                if (cur_op == 8'h27) mstat = mstat & ~(8'(dat0_log[nlog]) & 8'h70);
                cmd_done = 1;
                nlog++;
                @(negedge clk);
                cmd_done = 0;
            end
        end
    end

    task automatic pulse_start(input logic tx, input logic rx);
        @(negedge clk);
        start_tx = tx; start_rx = rx;
        @(negedge clk);
        start_tx = 0; start_rx = 0;
    endtask

    task automatic wait_done;
        do @(negedge clk); while (!done);
    endtask

    task automatic t_init;
        logic [7:0] regs [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h11, 8'h10, 8'h0A};
        int vals [8] = '{'h0F, 'h01, 'h01, 'h02, 'h1A, 'h00, 'h07, PLD_W};
        @(negedge clk);
        chk("R1 ce low after reset", int'(ce), 0);
        chk("R1 busy during init", int'(busy), 1);
        repeat (4) @(negedge clk);
        start_tx = 1; @(negedge clk); start_tx = 0;     // R3: ignored while busy
        while (busy) @(negedge clk);
        chk("R2 ce high after init", int'(ce), 1);
        repeat (20) @(negedge clk);
        chk("R3 no command from start during init", nlog, 10);
        chk("R2 ce steady while idle", int'(ce), 1);
        for (int i = 0; i < 10; i++) chk("R1 init opcode", int'(op_log[i]), int'(8'h20 | regs[i]));
        for (int i = 0; i < 8; i++)  chk("R1 init value", dat0_log[i], vals[i]);
        chk("R12 tx address length", len_log[8], 5);
        chk("R12 pipe address length", len_log[9], 5);
        for (int k = 0; k < 5; k++) begin
            chk("R12 tx address byte", int'(wlog[wstart[8] + k]), int'(ADDR[8*k +: 8]));
            chk("R12 pipe address byte", int'(wlog[wstart[9] + k]), int'(ADDR[8*k +: 8]));
        end
    endtask

    task automatic t_tx;
        int base = nlog;
        for (int k = 0; k < PLD_W; k++) pay[k] = 8'(8'h3C + 29 * k);
        hidx = 0;
        pulse_start(1, 0);
        while (nlog == base) @(negedge clk);
        start_rx = 1; @(negedge clk); start_rx = 0;     // R3: ignored while busy
        wait_done;
        chk("R9 busy low with done", int'(busy), 0);
        chk("R9 rx_ok low after send", int'(rx_ok), 0);
        @(negedge clk);
        chk("R9 done lasts one cycle", int'(done), 0);
        repeat (10) @(negedge clk);
        chk("R3 start during send ignored", nlog - base, 2);
        chk("R4 load opcode", int'(op_log[base]), 'hA0);
        chk("R4 ce low at load", int'(ce_log[base]), 0);
        chk("R4 load length", len_log[base], PLD_W);
        for (int k = 0; k < PLD_W; k++)
            chk("R4 payload byte", int'(wlog[wstart[base] + k]), int'(8'(8'h3C + 29 * k)));
        chk("R4 mode write opcode", int'(op_log[base + 1]), 'h20);
        chk("R4 mode write value", dat0_log[base + 1], 'h0E);
        chk("R5 ce pulse width", ce_width, EXP_PULSE);
        chk("R5 ce low after pulse", int'(ce), 0);
    endtask

    task automatic t_rx_empty;
        int base = nlog;
        mstat = 8'h0E;
        pulse_start(0, 1);
        wait_done;
        chk("R9 rx_ok low without packet", int'(rx_ok), 0);
        chk("R9 busy low with done", int'(busy), 0);
        chk("R6 command count", nlog - base, 3);
        chk("R6 mode write opcode", int'(op_log[base]), 'h20);
        chk("R6 mode write value", dat0_log[base], 'h0F);
        chk("R6 ce low at mode write", int'(ce_log[base]), 0);
        chk("R6 poll opcode", int'(op_log[base + 1]), 'hFF);
        chk("R6 poll length", len_log[base + 1], 0);
        chk("R6 settle cycles", acc_cyc[base + 1] - ce_rise, EXP_SETTLE);
        chk("R8 write-back opcode", int'(op_log[base + 2]), 'h27);
        chk("R8 write-back value", dat0_log[base + 2], 'h0E);
        chk("R10 ce stays high", int'(ce), 1);
    endtask

    task automatic t_rx_data;
        int base = nlog;
        for (int k = 0; k < PLD_W; k++) rxpay[k] = 8'(8'hE1 ^ (k * 17));
        nrx = 0;
        mstat = 8'h4E;
        pulse_start(0, 1);
        wait_done;
        chk("R9 rx_ok high with packet", int'(rx_ok), 1);
        chk("R7 command count", nlog - base, 4);
        chk("R7 read opcode", int'(op_log[base + 2]), 'h61);
        chk("R7 read length", len_log[base + 2], PLD_W);
        chk("R7 ce low at read", int'(ce_log[base + 2]), 0);
        chk("R7 bytes forwarded", nrx, PLD_W);
        for (int k = 0; k < PLD_W; k++)
            chk("R7 received byte", int'(rxcap[k]), int'(8'(8'hE1 ^ (k * 17))));
        chk("R8 write-back opcode", int'(op_log[base + 3]), 'h27);
        chk("R8 write-back value", dat0_log[base + 3], 'h4E);
        chk("R8 flags cleared in radio", int'(mstat), 'h0E);
        chk("R7 ce low after read", int'(ce), 0);
    endtask

    task automatic t_both;
        int base = nlog;
        hidx = 0;
        pulse_start(1, 1);
        wait_done;
        chk("R3 both starts: rx_ok low", int'(rx_ok), 0);
        repeat (10) @(negedge clk);
        chk("R3 both starts: send chosen", int'(op_log[base]), 'hA0);
        chk("R3 both starts: command count", nlog - base, 2);
        chk("R3 both starts: mode value", dat0_log[base + 1], 'h0E);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R9 watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        for (int k = 0; k < PLD_W; k++) begin pay[k] = 8'h00; rxpay[k] = 8'h00; end
        repeat (5) @(negedge clk);
        rst_n = 1;
        t_init();
        t_tx();
        t_rx_empty();
        t_rx_data();
        t_both();
        summary();
    end
endmodule